// File: doc/BRIEF.md
# Cross-Domain Mailbox Pair

This block holds two word-wide message registers that let two ports, each on its own clock, pass command and status words to each other without going through the data FIFO. Port A deposits a word in the forward mailbox, and port B picks it up. Port B deposits a word in the return mailbox, and port A picks it up. Each mailbox has an active-low occupancy flag in the domain of the port that writes it. A write pulls the flag LOW. The flag goes HIGH again only after the opposite port has read the mailbox and that read has crossed back into the writer's clock domain.

Each mailbox is built from a writer-side state machine with two states, EMPTY and FULL, and a reader-side state machine with two states, IDLE and PENDING. The two sides exchange events through toggle signals and flop synchronizers. Writer transitions:
- EMPTY to FULL on an accepted mailbox write.
- FULL to EMPTY when a release toggle arrives.

Reader transitions:
- IDLE to PENDING when a put toggle arrives.
- PENDING to IDLE on a mailbox read.

A read never changes the stored word. Port A always drives the return mailbox on its data output. Port B drives either the FIFO word or the forward mailbox, chosen by its mailbox select.

Top module: `xport_mailbox`

## Requirements
- R1: After reset both flags (`a_fwd_full_n`, `b_ret_full_n`) are HIGH and both mailbox words are all zeros.
- R2: A port access is selected when its chip select is LOW and its enable is HIGH. A selected access with write HIGH and mailbox select HIGH, made while the mailbox is EMPTY, stores the input word into the forward mailbox and drives `a_fwd_full_n` LOW after that `clk_a` edge.
- R3: While a mailbox flag is LOW, any write to that mailbox is ignored and the stored word is unchanged.
- R4: A write with mailbox select LOW, chip select HIGH or enable LOW neither changes the mailbox nor lowers its flag.
- R5: `b_dout` equals `fifo_word` when `b_mbx` is LOW and the forward mailbox when `b_mbx` is HIGH. The path is combinational.
- R6: `a_dout` always equals the return mailbox, whatever the port A control inputs are.
- R7: A port B read with `b_mbx` HIGH, made while its reader is PENDING, sets `a_fwd_full_n` HIGH within SYNC_STAGES+1 `clk_a` edges after the read edge. The return mailbox mirrors this, with port A reading and `b_ret_full_n` set in `clk_b`.
- R8: A mailbox read leaves the stored word unchanged, so a repeated read returns the same word.
- R9: A mailbox read made while the reader is IDLE is ignored. It does not release a word written afterwards.
- R10: Port B writes the return mailbox with the same selection rules on `clk_b`, and `b_ret_full_n` goes LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction, HIGH = write |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Return mailbox contents |
| a_fwd_full_n | output | 1 | Forward mailbox flag, LOW = full |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction, HIGH = write |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | DATA_W | Port B write data |
| fifo_word | input | DATA_W | Word from the FIFO output register |
| b_dout | output | DATA_W | Port B read data |
| b_ret_full_n | output | 1 | Return mailbox flag, LOW = full |

## Verification
The bench builds the block with DATA_W=36 and SYNC_STAGES=2. The full word width lets distinct patterns separate FIFO data from mail data, including patterns that differ only in the top bit. The short synchronizer keeps the release path to three writer edges, so a bench poll of a dozen cycles settles every flag transition. The two clocks run at unrelated periods, which moves the toggle crossings to different phases. That reaches the read-before-write race behind R9 and the blocked-write window behind R3.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    typedef enum logic {
        W_EMPTY = 1'b0,
        W_FULL  = 1'b1
    } wr_state_e;

    typedef enum logic {
        R_IDLE    = 1'b0,
        R_PENDING = 1'b1
    } rd_state_e;
endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[gi] <= 1'b0;
                else        chain[gi] <= chain[gi-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_writer.sv
`timescale 1ns/1ps
module mbx_writer
    import mbx_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] din,
    input  logic              rel_tog,
    output logic [DATA_W-1:0] data_q,
    output logic              flag_n,
    output logic              put_tog
);
    wr_state_e state, state_nx;
    logic      rel_s, rel_prev, rel_evt;
    logic      accept;

    mbx_sync #(.STAGES(SYNC_STAGES)) u_rel_sync (
        .clk(clk), .rst_n(rst_n), .d(rel_tog), .q(rel_s)
    );

    assign rel_evt = rel_s ^ rel_prev;
    assign accept  = (state == W_EMPTY) && wr_hit;

    always_comb begin
        state_nx = state;
        unique case (state)
            W_EMPTY: if (wr_hit)  state_nx = W_FULL;
            W_FULL:  if (rel_evt) state_nx = W_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= W_EMPTY;
            rel_prev <= 1'b0;
        end else begin
            state    <= state_nx;
            rel_prev <= rel_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            put_tog <= 1'b0;
        end else if (accept) begin
            data_q  <= din;
            put_tog <= ~put_tog;
        end
    end

    assign flag_n = (state == W_EMPTY);

    a_r2_write_lowers_flag: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !flag_n);
    a_r3_full_holds_word: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_n |=> $stable(data_q));
    a_r7_release_from_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_n) |-> $past(rel_evt));
endmodule

// File: rtl/mbx_reader.sv
`timescale 1ns/1ps
module mbx_reader
    import mbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    input  logic put_tog,
    output logic rel_tog
);
    rd_state_e state, state_nx;
    logic      put_s, put_prev, put_evt;

    mbx_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
        .clk(clk), .rst_n(rst_n), .d(put_tog), .q(put_s)
    );

    assign put_evt = put_s ^ put_prev;

    always_comb begin
        state_nx = state;
        unique case (state)
            R_IDLE:    if (put_evt) state_nx = R_PENDING;
            R_PENDING: if (rd_hit)  state_nx = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= R_IDLE;
            put_prev <= 1'b0;
        end else begin
            state    <= state_nx;
            put_prev <= put_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 rel_tog <= 1'b0;
        else if ((state == R_PENDING) && rd_hit)    rel_tog <= ~rel_tog;
    end

    a_r9_release_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_tog != $past(rel_tog)) |-> $past(state == R_PENDING));
endmodule

// File: rtl/xport_mailbox.sv
`timescale 1ns/1ps
module xport_mailbox #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              a_cs_n,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_mbx,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_fwd_full_n,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              b_cs_n,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_mbx,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] fifo_word,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_ret_full_n
);
    logic              a_sel, b_sel;
    logic              a_put, a_take, b_put, b_take;
    logic [DATA_W-1:0] fwd_word, ret_word;
    logic              fwd_put_tog, fwd_rel_tog, ret_put_tog, ret_rel_tog;

    assign a_sel  = !a_cs_n && a_en && a_mbx;
    assign b_sel  = !b_cs_n && b_en && b_mbx;
    assign a_put  = a_sel &&  a_wr;
    assign a_take = a_sel && !a_wr;
    assign b_put  = b_sel &&  b_wr;
    assign b_take = b_sel && !b_wr;

    // forward mailbox: written in clk_a, read in clk_b
    mbx_writer #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_fwd_wr (
        .clk(clk_a), .rst_n(rst_a_n), .wr_hit(a_put), .din(a_din),
        .rel_tog(fwd_rel_tog), .data_q(fwd_word), .flag_n(a_fwd_full_n),
        .put_tog(fwd_put_tog)
    );
    mbx_reader #(.SYNC_STAGES(SYNC_STAGES)) u_fwd_rd (
        .clk(clk_b), .rst_n(rst_b_n), .rd_hit(b_take),
        .put_tog(fwd_put_tog), .rel_tog(fwd_rel_tog)
    );

    // return mailbox: written in clk_b, read in clk_a
    mbx_writer #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ret_wr (
        .clk(clk_b), .rst_n(rst_b_n), .wr_hit(b_put), .din(b_din),
        .rel_tog(ret_rel_tog), .data_q(ret_word), .flag_n(b_ret_full_n),
        .put_tog(ret_put_tog)
    );
    mbx_reader #(.SYNC_STAGES(SYNC_STAGES)) u_ret_rd (
        .clk(clk_a), .rst_n(rst_a_n), .rd_hit(a_take),
        .put_tog(ret_put_tog), .rel_tog(ret_rel_tog)
    );

    assign a_dout = ret_word;
    assign b_dout = b_mbx ? fwd_word : fifo_word;

    a_r8_read_keeps_fwd: assert property (@(posedge clk_b) disable iff (!rst_b_n || !rst_a_n)
        (b_take && a_fwd_full_n == 1'b0 && !a_put) |=> $stable(fwd_word));
endmodule

// File: tb/sim_xport_mailbox.sv
`timescale 1ns/1ps
module sim_xport_mailbox;
    localparam int W = 36;

    logic         clk_a = 1'b0, clk_b = 1'b0;
    logic         rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic         a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_mbx = 1'b0;
    logic         b_cs_n = 1'b1, b_en = 1'b0, b_wr = 1'b0, b_mbx = 1'b0;
    logic [W-1:0] a_din = '0, b_din = '0, fifo_word = '0;
    logic [W-1:0] a_dout, b_dout;
    logic         a_fwd_full_n, b_ret_full_n;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] q_fwd[$];
    logic [W-1:0] q_ret[$];

    always #4   clk_a = ~clk_a;
    always #6.5 clk_b = ~clk_b;

    xport_mailbox #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_cs_n(a_cs_n), .a_en(a_en),
        .a_wr(a_wr), .a_mbx(a_mbx), .a_din(a_din), .a_dout(a_dout),
        .a_fwd_full_n(a_fwd_full_n),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .b_cs_n(b_cs_n), .b_en(b_en),
        .b_wr(b_wr), .b_mbx(b_mbx), .b_din(b_din), .fifo_word(fifo_word),
        .b_dout(b_dout), .b_ret_full_n(b_ret_full_n)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitors: pop expected mailbox words as reads are seen
    always @(posedge clk_b) begin
        if (!b_cs_n && b_en && !b_wr && b_mbx && q_fwd.size() > 0) begin
            logic [W-1:0] e;
            e = q_fwd.pop_front();
            check(b_dout == e, "R8 fwd read word", b_dout, e);
        end
    end
    always @(posedge clk_a) begin
        if (!a_cs_n && a_en && !a_wr && a_mbx && q_ret.size() > 0) begin
            logic [W-1:0] e;
            e = q_ret.pop_front();
            check(a_dout == e, "R6 ret read word", a_dout, e);
        end
    end

    task automatic a_op(input logic wr, input logic mbx, input logic cs_n,
                        input logic en, input logic [W-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbx = mbx; a_din = d;
        @(negedge clk_a);
        a_cs_n = 1'b1; a_en = 1'b0; a_wr = 1'b0; a_mbx = 1'b0;
    endtask

    task automatic b_op(input logic wr, input logic [W-1:0] d);
        @(negedge clk_b);
        b_cs_n = 1'b0; b_en = 1'b1; b_wr = wr; b_mbx = 1'b1; b_din = d;
        @(negedge clk_b);
        b_cs_n = 1'b1; b_en = 1'b0; b_wr = 1'b0; b_mbx = 1'b0;
    endtask

    task automatic b_read(input logic [W-1:0] exp);
        q_fwd.push_back(exp);
        b_op(1'b0, '0);
    endtask

    task automatic a_read(input logic [W-1:0] exp);
        q_ret.push_back(exp);
        a_op(1'b0, 1'b1, 1'b0, 1'b1, '0);
    endtask

    task automatic wait_a_flag(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk_a);
            if (a_fwd_full_n) begin seen = 1'b1; break; end
        end
    endtask

    task automatic wait_b_flag(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk_b);
            if (b_ret_full_n) begin seen = 1'b1; break; end
        end
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", '0, '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic seen;
        logic [W-1:0] w1, w2, w3, r1;
        w1 = 36'hA5A5_1234_5;
        w2 = 36'h8_0000_0001;
        w3 = 36'h3_CAFE_F00D;
        r1 = 36'hF_0F0F_0F0F;
        fifo_word = 36'h1_2345_6789;
        #30;
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        repeat (3) @(negedge clk_a);

        // R1 reset state
        check(a_fwd_full_n == 1'b1, "R1 fwd flag after reset", W'(a_fwd_full_n), W'(1));
        check(b_ret_full_n == 1'b1, "R1 ret flag after reset", W'(b_ret_full_n), W'(1));
        check(a_dout == '0, "R1 ret word after reset", a_dout, '0);
        b_mbx = 1'b1; #1;
        check(b_dout == '0, "R1 fwd word after reset", b_dout, '0);
        b_mbx = 1'b0; #1;
        check(b_dout == fifo_word, "R5 fifo path", b_dout, fifo_word);

        // R4 unselected writes
        a_op(1'b1, 1'b0, 1'b0, 1'b1, w3);
        a_op(1'b1, 1'b1, 1'b1, 1'b1, w3);
        a_op(1'b1, 1'b1, 1'b0, 1'b0, w3);
        @(negedge clk_a);
        check(a_fwd_full_n == 1'b1, "R4 flag stays high", W'(a_fwd_full_n), W'(1));
        b_mbx = 1'b1; #1;
        check(b_dout == '0, "R4 fwd word untouched", b_dout, '0);
        b_mbx = 1'b0;

        // R9 read with no mail, then write; flag must stay low
        b_read('0);
        repeat (2) @(negedge clk_b);
        a_op(1'b1, 1'b1, 1'b0, 1'b1, w1);
        check(a_fwd_full_n == 1'b0, "R2 write lowers flag", W'(a_fwd_full_n), W'(0));
        repeat (20) @(negedge clk_a);
        check(a_fwd_full_n == 1'b0, "R9 early read ignored", W'(a_fwd_full_n), W'(0));

        // R3 blocked write
        a_op(1'b1, 1'b1, 1'b0, 1'b1, w3);
        @(negedge clk_b);
        b_mbx = 1'b1; #1;
        check(b_dout == w1, "R3 blocked write ignored", b_dout, w1);
        check(b_dout == w1, "R5 mail path", b_dout, w1);
        b_mbx = 1'b0; #1;
        check(b_dout == fifo_word, "R5 back to fifo", b_dout, fifo_word);

        // R7 read releases flag; R8 repeat read same word
        b_read(w1);
        wait_a_flag(seen);
        check(seen, "R7 fwd flag released", W'(a_fwd_full_n), W'(1));
        b_read(w1);
        b_mbx = 1'b1; #1;
        check(b_dout == w1, "R8 word kept after read", b_dout, w1);
        b_mbx = 1'b0;

        // second round with top-bit pattern
        a_op(1'b1, 1'b1, 1'b0, 1'b1, w2);
        check(a_fwd_full_n == 1'b0, "R2 second write", W'(a_fwd_full_n), W'(0));
        repeat (8) @(negedge clk_b);
        b_read(w2);
        wait_a_flag(seen);
        check(seen, "R7 second release", W'(a_fwd_full_n), W'(1));

        // R10 return mailbox
        b_op(1'b1, r1);
        check(b_ret_full_n == 1'b0, "R10 ret write lowers flag", W'(b_ret_full_n), W'(0));
        @(negedge clk_a);
        check(a_dout == r1, "R6 a_dout shows ret", a_dout, r1);
        b_op(1'b1, w3);
        @(negedge clk_a);
        check(a_dout == r1, "R3 ret blocked write", a_dout, r1);
        a_mbx = 1'b0; a_cs_n = 1'b1; #1;
        check(a_dout == r1, "R6 independent of a_mbx", a_dout, r1);
        repeat (8) @(negedge clk_a);
        a_read(r1);
        wait_b_flag(seen);
        check(seen, "R7 ret flag released", W'(b_ret_full_n), W'(1));
        @(negedge clk_a);
        check(a_dout == r1, "R8 ret word kept", a_dout, r1);

        repeat (4) @(negedge clk_a);
        check(q_fwd.size() == 0 && q_ret.size() == 0, "R8 all reads seen",
              W'(q_fwd.size() + q_ret.size()), '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule